// File: doc/BRIEF.md
# Logic Probe Activity Indicator

This block holds the indicator logic of a logic probe. Two comparator flags come from the probe tip. One is set while the tip is above the upper logic threshold and the other while it is below the lower threshold. The block drives three indicator outputs: a high-level lamp, a low-level lamp and an activity lamp. The level lamps follow the tip as it is. When the tip sits between the two thresholds, as it does on a floating pin or an out-of-tolerance signal, both level lamps are dark.

Activity means a change from one valid level to the other. A pass through the dead band counts only if the tip comes out on the opposite side. In pulse mode each change lights the activity lamp for a fixed on-time, however narrow the input pulse was. The lamp then goes dark for a fixed gap before it can light again. Under constant activity it therefore blinks at a steady rate of about 3 Hz instead of glowing solidly. In memory mode the first change latches the lamp on. The operator clears the latch by moving the mode input to pulse and rearms it by moving the input back to memory. The flags and the mode input are asynchronous and pass through a synchronizer first. All durations are counts of the system clock.

Top module: `probe_activity_ind`

## Requirements
- R1: `hi_led` is 1 exactly when the synchronized above-threshold flag is 1 and the synchronized below-threshold flag is 0. It has no memory of earlier levels.
- R2: `lo_led` is 1 exactly when the synchronized below-threshold flag is 1 and the synchronized above-threshold flag is 0. It has no memory of earlier levels.
- R3: When both synchronized flags are 0 (dead band) or both are 1, `hi_led` and `lo_led` are both 0. The two are never 1 together.
- R4: An activity event is counted only when the tip moves from one valid level to the other. A dead-band excursion that returns to the same level counts nothing. The first valid level seen after reset counts nothing.
- R5: With `mode_mem`=0 (pulse mode), an event seen while the stretcher is idle lights `pulse_led` for exactly ON_CYC cycles. This holds even for an input pulse one clock wide. The lamp lights three clock edges after the edge that first samples the change.
- R6: The stretcher cannot be retriggered. Events during the on-time or during the following GAP_CYC dark cycles are ignored. Under an event on every cycle the lamp repeats ON_CYC cycles on and GAP_CYC+1 cycles off.
- R7: With `mode_mem`=1 (memory mode), the first event sets `pulse_led` to 1. It stays 1 for as long as the mode input stays at 1.
- R8: Setting `mode_mem` to 0 clears the memory latch. After `mode_mem` returns to 1, `pulse_led` stays 0 until the next event.
- R9: While `rst_n` is 0, all three outputs are 0.
- R10: `tip_above_hi`, `tip_below_lo` and `mode_mem` each pass through a two-flop synchronizer. A change sampled at one edge reaches the level lamps after the following edge, not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tip_above_hi | input | 1 | Asynchronous flag: tip above the upper threshold |
| tip_below_lo | input | 1 | Asynchronous flag: tip below the lower threshold |
| mode_mem | input | 1 | 1 selects memory mode, 0 selects pulse mode |
| hi_led | output | 1 | High-level indicator |
| lo_led | output | 1 | Low-level indicator |
| pulse_led | output | 1 | Activity indicator (stretched or latched) |

## Verification
The hardest case to reach is an event that arrives while the stretcher is in its dark gap. That event must be dropped, and the lamp must not light one cycle early. The stimulus reaches this case by toggling the tip on every clock for dozens of cycles, so that an event is present on every edge of the on-time, the gap and the idle cycle. The measured on-run and off-run lengths must then come out as exactly ON_CYC and GAP_CYC+1. A single one-cycle glitch produces two events back to back and checks the same rule on a smaller scale. Dead-band round trips and a mode-switch clear/rearm sequence cover the remaining paths.

// File: rtl/probe_ind_pkg.sv
package probe_ind_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        STR_IDLE = 2'd0,
        STR_ON   = 2'd1,
        STR_GAP  = 2'd2
    } str_e;

    typedef struct packed {
        lvl_e last;
        logic evt;
    } edge_st_t;

    typedef struct packed {
        logic mem;
    } latch_st_t;

    function automatic int unsigned pmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = d;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/probe_level_edge.sv
module probe_level_edge
    import probe_ind_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_s,
    input  logic lo_s,
    output logic hi_led,
    output logic lo_led,
    output logic evt
);
    edge_st_t st_d, st_q;
    lvl_e     cur;

    always_comb begin
        if (hi_s && !lo_s)      cur = LVL_HIGH;
        else if (lo_s && !hi_s) cur = LVL_LOW;
        else                    cur = LVL_NONE;

        st_d     = st_q;
        st_d.evt = (cur != LVL_NONE) && (st_q.last != LVL_NONE) && (cur != st_q.last);
        if (cur != LVL_NONE) st_d.last = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: LVL_NONE, evt: 1'b0};
        else        st_q <= st_d;
    end

    assign hi_led = (cur == LVL_HIGH);
    assign lo_led = (cur == LVL_LOW);
    assign evt    = st_q.evt;
endmodule

// File: rtl/probe_stretcher.sv
module probe_stretcher
    import probe_ind_pkg::*;
#(
    parameter int unsigned ON_CYC  = 8,
    parameter int unsigned GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic on
);
    localparam int unsigned CNT_W = $clog2(pmax(ON_CYC, GAP_CYC) + 1);

    typedef struct packed {
        str_e             st;
        logic [CNT_W-1:0] cnt;
    } str_t;

    str_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            STR_IDLE: begin
                if (evt) begin
                    s_d.st  = STR_ON;
                    s_d.cnt = CNT_W'(ON_CYC - 1);
                end
            end
            STR_ON: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = STR_GAP;
                    s_d.cnt = CNT_W'(GAP_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            STR_GAP: begin
                if (s_q.cnt == '0) s_d.st  = STR_IDLE;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d = '{st: STR_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: STR_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign on = (s_q.st == STR_ON);
endmodule

// File: rtl/probe_activity_ind.sv
module probe_activity_ind
    import probe_ind_pkg::*;
#(
    parameter int unsigned ON_CYC      = 15_000_000,
    parameter int unsigned GAP_CYC     = 1_666_666,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tip_above_hi,
    input  logic tip_below_lo,
    input  logic mode_mem,
    output logic hi_led,
    output logic lo_led,
    output logic pulse_led
);
    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in, syn_out;
    logic              hi_s, lo_s, mode_s;
    logic              evt_q, stretch_on, mem_q;
    latch_st_t         lt_d, lt_q;

    assign raw_in = {mode_mem, tip_below_lo, tip_above_hi};

    probe_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
    );

    assign hi_s   = syn_out[0];
    assign lo_s   = syn_out[1];
    assign mode_s = syn_out[2];

    probe_level_edge u_edge (
        .clk(clk), .rst_n(rst_n), .hi_s(hi_s), .lo_s(lo_s),
        .hi_led(hi_led), .lo_led(lo_led), .evt(evt_q)
    );

    probe_stretcher #(.ON_CYC(ON_CYC), .GAP_CYC(GAP_CYC)) u_str (
        .clk(clk), .rst_n(rst_n), .evt(evt_q), .on(stretch_on)
    );

    always_comb begin
        lt_d = lt_q;
        if (!mode_s)    lt_d.mem = 1'b0;
        else if (evt_q) lt_d.mem = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_q <= '{mem: 1'b0};
        else        lt_q <= lt_d;
    end

    assign mem_q     = lt_q.mem;
    assign pulse_led = mode_s ? mem_q : stretch_on;
endmodule

// File: rtl/probe_activity_ind_chk.sv
module probe_activity_ind_chk #(
    parameter int unsigned ON_CYC  = 8,
    parameter int unsigned GAP_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic hi_led,
    input logic lo_led,
    input logic pulse_led,
    input logic mode_s,
    input logic evt,
    input logic stretch_on,
    input logic mem_on
);
    int unsigned on_run, off_run;
    logic        prev_on, seen_fall;

    AST_LEVEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_led && lo_led)); // R3

    AST_EVT_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(hi_led || lo_led)); // R4

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && $past(mode_s) && $past(pulse_led)) |-> pulse_led); // R7

    AST_MEM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_s) |-> !mem_on); // R8

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_run    <= 0;
            off_run   <= 0;
            prev_on   <= 1'b0;
            seen_fall <= 1'b0;
        end else begin
            prev_on <= stretch_on;
            if (stretch_on) begin
                on_run <= prev_on ? on_run + 1 : 1;
                if (!prev_on && seen_fall) begin
                    AST_GAP_LEN: assert (off_run >= GAP_CYC); // R6
                end
            end else begin
                off_run <= prev_on ? 1 : off_run + 1;
                if (prev_on) begin
                    seen_fall <= 1'b1;
                    AST_ON_LEN: assert (on_run == ON_CYC); // R5
                end
            end
        end
    end
endmodule

bind probe_activity_ind probe_activity_ind_chk #(.ON_CYC(ON_CYC), .GAP_CYC(GAP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .hi_led(hi_led), .lo_led(lo_led), .pulse_led(pulse_led),
    .mode_s(mode_s), .evt(evt_q), .stretch_on(stretch_on), .mem_on(mem_q)
);

// File: tb/probe_activity_ind_tb.sv
module probe_activity_ind_tb;
    localparam int ON  = 8;
    localparam int GAP = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, mode = 1'b0;
    logic hi_led, lo_led, pulse_led;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    probe_activity_ind #(.ON_CYC(ON), .GAP_CYC(GAP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .tip_above_hi(above), .tip_below_lo(below),
        .mode_mem(mode), .hi_led(hi_led), .lo_led(lo_led), .pulse_led(pulse_led)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: delayed view of inputs, level memory, timers
    logic [2:0] dly1 = '0, dly2 = '0;   // {mode, below, above}
    int  m_last = 0;                    // 0 none, 1 low, 2 high
    bit  m_evt = 0, m_mem = 0;
    int  on_left = 0, gap_left = 0;
    bit  e_hi, e_lo, e_pulse;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly1 = '0; dly2 = '0; m_last = 0; m_evt = 0; m_mem = 0;
            on_left = 0; gap_left = 0;
        end else begin
            int cur;
            cyc++;
            if (on_left > 0) begin
                on_left--;
                if (on_left == 0) gap_left = GAP;
            end else if (gap_left > 0) gap_left--;
            else if (m_evt) on_left = ON;
            if (!dly2[2]) m_mem = 0;
            else if (m_evt) m_mem = 1;
            cur = (dly2[0] && !dly2[1]) ? 2 : (dly2[1] && !dly2[0]) ? 1 : 0;
            m_evt = (cur != 0) && (m_last != 0) && (cur != m_last);
            if (cur != 0) m_last = cur;
            dly2 = dly1;
            dly1 = {mode, below, above};
        end
        e_hi    = dly2[0] && !dly2[1];
        e_lo    = dly2[1] && !dly2[0];
        e_pulse = dly2[2] ? m_mem : (on_left > 0);
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R9 hi_led in reset", hi_led, 0);
            chk("R9 lo_led in reset", lo_led, 0);
            chk("R9 pulse_led in reset", pulse_led, 0);
        end else if (!done) begin
            chk("R1 hi_led", hi_led, e_hi);
            chk("R2 lo_led", lo_led, e_lo);
            chk(dly2[2] ? "R7 pulse_led memory" : "R5 pulse_led stretch", pulse_led, e_pulse);
        end
    end

    task automatic tip(input logic a, input logic b);
        above = a; below = b;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_pulse(input int n, output int hc);
        hc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_led) hc++;
        end
    endtask

    initial begin
        int hc;
        bit samp [64];
        int first, run1, off1, run2, idx;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk("R9 pulse after reset", pulse_led, 0);

        // first valid level after reset: no event (R4)
        tip(1, 0);
        count_pulse(15, hc);
        chk("R4 first level no event", hc, 0);
        chk("R1 hi steady", hi_led, 1);

        // R10: two edges before the level lamps move
        @(negedge clk); tip(0, 1);
        @(negedge clk); chk("R10 one edge later unchanged", lo_led, 0);
        @(negedge clk); chk("R10 two edges later", lo_led, 1);
        count_pulse(20, hc);
        chk("R5 single transition stretch length", hc, ON);
        chk("R2 lo steady", lo_led, 1);

        // dead band round trip (R3, R4)
        tip(0, 0); wait_n(4);
        chk("R3 deadband hi off", hi_led, 0);
        chk("R3 deadband lo off", lo_led, 0);
        tip(0, 1);
        count_pulse(20, hc);
        chk("R4 deadband round trip no event", hc, 0);
        tip(1, 1); wait_n(4);
        chk("R3 both flags hi off", hi_led, 0);
        chk("R3 both flags lo off", lo_led, 0);
        tip(0, 1); wait_n(20);
        tip(0, 0); wait_n(3); tip(1, 0);
        count_pulse(20, hc);
        chk("R4 low through deadband to high", hc, ON);

        // one-cycle glitch: two events, one stretch (R5, R6)
        tip(0, 1); wait_n(25);
        @(negedge clk); tip(1, 0);
        @(negedge clk); tip(0, 1);
        count_pulse(25, hc);
        chk("R5 narrow glitch stretched once", hc, ON);

        // continuous activity (R6)
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            samp[i] = pulse_led;
            if (i % 2 == 0) tip(1, 0); else tip(0, 1);
        end
        first = -1;
        for (int i = 0; i < 64; i++) if (first < 0 && samp[i]) first = i;
        idx = (first < 0) ? 0 : first;
        run1 = 0; while (idx < 64 && samp[idx])  begin run1++; idx++; end
        off1 = 0; while (idx < 64 && !samp[idx]) begin off1++; idx++; end
        run2 = 0; while (idx < 64 && samp[idx])  begin run2++; idx++; end
        chk("R6 first on-run", run1, ON);
        chk("R6 forced off-run", off1, GAP + 1);
        chk("R6 second on-run", run2, ON);
        tip(0, 1); wait_n(25);

        // memory mode (R7)
        mode = 1'b1; wait_n(5);
        chk("R7 armed, no event yet", pulse_led, 0);
        tip(1, 0);
        count_pulse(40, hc);
        chk("R7 latched through long hold", hc, 40 - 3);
        chk("R7 still latched", pulse_led, 1);

        // clear and rearm (R8)
        mode = 1'b0; wait_n(5);
        chk("R8 pulse mode clears", pulse_led, 0);
        mode = 1'b1; wait_n(5);
        chk("R8 rearmed dark", pulse_led, 0);
        tip(0, 1); wait_n(5);
        chk("R8 rearmed latch catches event", pulse_led, 1);
        mode = 1'b0; wait_n(20);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait_n(100000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule